// File: doc/BRIEF.md
# Fetch Address Region Remapper

This block sits on an instruction fetch path and redirects selected address windows to another place in the address map. It holds a small set of region descriptors. Each descriptor is a power-of-two window, from 2 MB to 128 MB, inside the 512 MB code space, and carries a target location, an output port choice and an output burst type. Every fetch address is compared against all enabled descriptors at once. The winning descriptor replaces the upper address bits with its target and passes the offset inside the window through unchanged. An address that hits no window leaves the block unmodified on the default port.

Descriptors are written through a simple one-cycle write strobe. The write path is guarded. Nothing may change while the surrounding cache is switched on, and a live descriptor cannot be overwritten in place. It must first be switched off with a write whose enable is low, and only then given new contents. A write that is accepted takes effect from the next clock edge. The fetch translation itself is purely combinational.

Top module: `addrRemapper`

## Requirements
- R1: After reset every region is disabled, so each fetch address leaves on `outAddr` unchanged with `outHit`=0.
- R2: Size code k in 1..7 gives a window of 2^k MB (1 = 2 MB, 7 = 128 MB). A region whose size code is 0 never matches, even when it is enabled.
- R3: An enabled region with size code k matches when fetch bits [28:21] equal the base field on the upper 9-k of those eight bits. The lower k-1 bits of the base and fetch bits [31:29] are ignored.
- R4: On a match, `outAddr` bits [31:20+k] come from the remap field bits [10:k-1]. Bits [19+k:0] are copied from the fetch address, so bits [20:0] always pass through.
- R5: On a match, `outPort` is the region's port bit and `outBurst` is its burst bit (0 = wrapping, 1 = incrementing). `outHit` is 1 and `hitRegion` gives the region index.
- R6: When several regions match, the region with the lowest index supplies address, port, burst and `hitRegion`.
- R7: With no match, `outAddr` equals `fetchAddr`, `outPort`=0, `outBurst`=1 (incrementing), `outHit`=0 and `hitRegion`=0.
- R8: While `cacheEnable` is 1, every configuration write is ignored, including a write that would disable a region.
- R9: While `cacheEnable` is 0, a write with `cfgEnable`=1 to a region that is already enabled is ignored. A write with `cfgEnable`=0 is accepted and disables the region. A write with `cfgEnable`=1 to a disabled region loads all fields and enables it from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cacheEnable | input | 1 | Cache switched on; freezes all descriptors |
| cfgWrite | input | 1 | One-cycle descriptor write strobe |
| cfgIdx | input | 2 | Region index targeted by the write |
| cfgEnable | input | 1 | Enable value carried by the write |
| cfgSizeCode | input | 3 | Window size code, 1 = 2 MB up to 7 = 128 MB |
| cfgBase | input | 8 | Window base, address bits [28:21] |
| cfgRemap | input | 11 | Target, address bits [31:21] |
| cfgPort | input | 1 | Output port select for the region |
| cfgBurst | input | 1 | Burst type, 0 wrapping, 1 incrementing |
| fetchAddr | input | 32 | Incoming fetch address |
| outAddr | output | 32 | Translated address |
| outPort | output | 1 | Selected output port |
| outBurst | output | 1 | Selected burst type |
| outHit | output | 1 | A region matched |
| hitRegion | output | 2 | Index of the winning region |

## Verification
The hardest case to reach from the ports is a refused write. It leaves no trace of its own, so the bench proves it by showing that translation still follows the old descriptor afterwards. It also shows that the same write is later accepted once the blocking condition is gone. Window edges are a second difficulty. Each size code is swept over several bases, and the probes sit exactly on the first and last byte of the window, just outside it, and on aliases that differ only in bits [31:29]. A set of stacked, overlapping regions of different sizes then shows that the lowest index wins wherever windows overlap.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFFS_W  = 21;   // 2 MB granule
  localparam int BASE_W  = 8;    // bits [28:21]
  localparam int REMAP_W = ADDR_W - OFFS_W;  // bits [31:21]
  localparam int SIZE_W  = 3;

  typedef struct packed {
    logic [SIZE_W-1:0]  sizeCode;
    logic [BASE_W-1:0]  base;
    logic [REMAP_W-1:0] remap;
    logic               port;
    logic               burst;
  } region_cfg_t;

  typedef struct packed {
    logic        en;
    region_cfg_t cfg;
  } region_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // accepted write
    logic arm;   // enable value stored with it
  } cfg_strobe_t;

  // bits of the upper field that come from the region (1) vs the fetch (0)
  function automatic logic [REMAP_W-1:0] keepMask(input logic [SIZE_W-1:0] code);
    logic [REMAP_W-1:0] m;
    m = '1;
    if (code == '0) m = '0;
    else            m = m << (code - 1'b1);
    return m;
  endfunction
endpackage

// File: rtl/remapCtrl.sv
module remapCtrl
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                   cacheEnable,
  input  logic                   cfgWrite,
  input  logic [IDX_W-1:0]       cfgIdx,
  input  logic                   cfgEnable,
  input  logic [NUM_REGIONS-1:0] enVec,
  output cfg_strobe_t            strobe
);
  logic liveTarget;
  logic frozen;

  always_comb begin
    liveTarget = enVec[cfgIdx];
    frozen     = cacheEnable;
    strobe.arm  = cfgEnable;
    // disabling is always allowed with the cache off; arming needs an idle slot
    strobe.load = cfgWrite && !frozen && !(liveTarget && cfgEnable);
  end
endmodule

// File: rtl/remapDatapath.sv
module remapDatapath
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS   = 4,
  parameter bit DEFAULT_PORT  = 1'b0,
  parameter bit DEFAULT_BURST = 1'b1,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cfg_strobe_t            strobe,
  input  logic [IDX_W-1:0]       cfgIdx,
  input  region_cfg_t            cfgIn,
  input  logic [ADDR_W-1:0]      fetchAddr,
  output logic [ADDR_W-1:0]      outAddr,
  output logic                   outPort,
  output logic                   outBurst,
  output logic                   outHit,
  output logic [IDX_W-1:0]       hitRegion,
  output logic [NUM_REGIONS-1:0] enVec
);
  region_t [NUM_REGIONS-1:0] regQ;
  logic [NUM_REGIONS-1:0]    matchVec;
  logic [REMAP_W-1:0]        hiVec [NUM_REGIONS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ <= '0;
    end else if (strobe.load) begin
      regQ[cfgIdx].en  <= strobe.arm;
      regQ[cfgIdx].cfg <= cfgIn;
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic [REMAP_W-1:0] keep;
    logic [BASE_W-1:0]  baseKeep;
    logic [BASE_W-1:0]  fetchSlot;
    always_comb begin
      keep        = keepMask(regQ[g].cfg.sizeCode);
      baseKeep    = keep[BASE_W-1:0];
      fetchSlot   = fetchAddr[OFFS_W +: BASE_W];
      enVec[g]    = regQ[g].en;
      matchVec[g] = regQ[g].en && (regQ[g].cfg.sizeCode != '0) &&
                    (((fetchSlot ^ regQ[g].cfg.base) & baseKeep) == '0);
      hiVec[g]    = (regQ[g].cfg.remap & keep) |
                    (fetchAddr[ADDR_W-1:OFFS_W] & ~keep);
    end
  end

  // descending scan so the lowest matching index is written last
  always_comb begin
    outAddr   = fetchAddr;
    outPort   = DEFAULT_PORT;
    outBurst  = DEFAULT_BURST;
    outHit    = 1'b0;
    hitRegion = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        outAddr   = {hiVec[i], fetchAddr[OFFS_W-1:0]};
        outPort   = regQ[i].cfg.port;
        outBurst  = regQ[i].cfg.burst;
        outHit    = 1'b1;
        hitRegion = IDX_W'(i);
      end
    end
  end

  // R4: the offset inside the smallest window never changes
  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    outAddr[OFFS_W-1:0] == fetchAddr[OFFS_W-1:0]);

  // R7: no hit means untouched address on the default route
  assert_passthrough_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outHit |-> (outAddr == fetchAddr && outPort == DEFAULT_PORT && outBurst == DEFAULT_BURST));

  // R3: a hit always points at a live region
  assert_hit_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    outHit |-> enVec[hitRegion]);

  // R9: an arming write never lands on a live region
  assert_no_rearm_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.arm) |-> !enVec[cfgIdx]);

  // R8/R9: without a load strobe the descriptors hold
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(regQ));
endmodule

// File: rtl/addrRemapper.sv
module addrRemapper
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS   = 4,
  parameter bit DEFAULT_PORT  = 1'b0,
  parameter bit DEFAULT_BURST = 1'b1,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cacheEnable,
  input  logic               cfgWrite,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic               cfgEnable,
  input  logic [SIZE_W-1:0]  cfgSizeCode,
  input  logic [BASE_W-1:0]  cfgBase,
  input  logic [REMAP_W-1:0] cfgRemap,
  input  logic               cfgPort,
  input  logic               cfgBurst,
  input  logic [ADDR_W-1:0]  fetchAddr,
  output logic [ADDR_W-1:0]  outAddr,
  output logic               outPort,
  output logic               outBurst,
  output logic               outHit,
  output logic [IDX_W-1:0]   hitRegion
);
  cfg_strobe_t            strobe;
  region_cfg_t            cfgIn;
  logic [NUM_REGIONS-1:0] enVec;

  always_comb begin
    cfgIn.sizeCode = cfgSizeCode;
    cfgIn.base     = cfgBase;
    cfgIn.remap    = cfgRemap;
    cfgIn.port     = cfgPort;
    cfgIn.burst    = cfgBurst;
  end

  remapCtrl #(.NUM_REGIONS(NUM_REGIONS)) i_ctrl (
    .cacheEnable (cacheEnable),
    .cfgWrite    (cfgWrite),
    .cfgIdx      (cfgIdx),
    .cfgEnable   (cfgEnable),
    .enVec       (enVec),
    .strobe      (strobe)
  );

  remapDatapath #(
    .NUM_REGIONS   (NUM_REGIONS),
    .DEFAULT_PORT  (DEFAULT_PORT),
    .DEFAULT_BURST (DEFAULT_BURST)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgIdx    (cfgIdx),
    .cfgIn     (cfgIn),
    .fetchAddr (fetchAddr),
    .outAddr   (outAddr),
    .outPort   (outPort),
    .outBurst  (outBurst),
    .outHit    (outHit),
    .hitRegion (hitRegion),
    .enVec     (enVec)
  );

  // R8: with the cache on, the set of live regions cannot change
  assert_cache_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    cacheEnable |=> $stable(enVec));
endmodule

// File: tb/test_addrRemapper.sv
module test_addrRemapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cacheEnable = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic        cfgEnable = 1'b0;
  logic [2:0]  cfgSizeCode = '0;
  logic [7:0]  cfgBase = '0;
  logic [10:0] cfgRemap = '0;
  logic        cfgPort = 1'b0;
  logic        cfgBurst = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic [31:0] outAddr;
  logic        outPort, outBurst, outHit;
  logic [1:0]  hitRegion;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // bench view of the descriptors, kept by the write rules
  bit          mEn[4];
  int unsigned mCode[4], mBase[4], mRemap[4];
  bit          mPort[4], mBurst[4];

  always #10 clk = ~clk;  // 50 MHz

  addrRemapper i_addrRemapper (
    .clk(clk), .rstN(rstN), .cacheEnable(cacheEnable), .cfgWrite(cfgWrite),
    .cfgIdx(cfgIdx), .cfgEnable(cfgEnable), .cfgSizeCode(cfgSizeCode),
    .cfgBase(cfgBase), .cfgRemap(cfgRemap), .cfgPort(cfgPort), .cfgBurst(cfgBurst),
    .fetchAddr(fetchAddr), .outAddr(outAddr), .outPort(outPort),
    .outBurst(outBurst), .outHit(outHit), .hitRegion(hitRegion)
  );

  task automatic writeRegion(input int idx, input bit en, input int unsigned code,
                             input int unsigned base, input int unsigned remap,
                             input bit port, input bit burst);
    @(negedge clk);
    cfgWrite = 1; cfgIdx = idx[1:0]; cfgEnable = en; cfgSizeCode = code[2:0];
    cfgBase = base[7:0]; cfgRemap = remap[10:0]; cfgPort = port; cfgBurst = burst;
    if (!cacheEnable && !(mEn[idx] && en)) begin
      mEn[idx] = en; mCode[idx] = code; mBase[idx] = base; mRemap[idx] = remap;
      mPort[idx] = port; mBurst[idx] = burst;
    end
    @(negedge clk);
    cfgWrite = 0;
  endtask

  task automatic probe(input logic [31:0] a, input string tag);
    longint unsigned la, sz, slot, expA;
    bit eP, eB, eH;
    int eR;
    la = a; expA = la; eP = 0; eB = 1; eH = 0; eR = 0;
    for (int r = 3; r >= 0; r--) begin
      if (mEn[r] && mCode[r] != 0) begin
        sz   = 64'd1 << (20 + mCode[r]);
        slot = (longint'(mBase[r]) << 21) / sz;
        if ((la % (64'd1 << 29)) / sz == slot) begin
          expA = (((longint'(mRemap[r]) << 21) / sz) * sz + (la % sz)) % (64'd1 << 32);
          eP = mPort[r]; eB = mBurst[r]; eH = 1; eR = r;
        end
      end
    end
    @(negedge clk);
    fetchAddr = a;
    #2;
    nChecks++;
    if (outAddr !== expA[31:0] || outPort !== eP || outBurst !== eB ||
        outHit !== eH || hitRegion !== eR[1:0]) begin
      nFails++;
      $display("FAIL %s addr=%h: got addr=%h port=%0d burst=%0d hit=%0d idx=%0d exp addr=%h port=%0d burst=%0d hit=%0d idx=%0d",
               tag, a, outAddr, outPort, outBurst, outHit, hitRegion,
               expA[31:0], eP, eB, eH, eR);
    end
  endtask

  task automatic sweepWindow(input int unsigned code, input int unsigned base, input string tag);
    longint unsigned sz, st;
    logic [31:0] s;
    sz = 64'd1 << (20 + code);
    st = ((longint'(base) << 21) / sz) * sz;
    s  = st[31:0];
    probe(s, tag);
    probe(s + sz[31:0] - 1, tag);
    probe(s + sz[31:0], tag);
    probe(s - 1, tag);
    probe(s + (sz[31:0] >> 1) + 32'h123, tag);
    probe(s | 32'hE000_0000, tag);
    probe((s + sz[31:0] - 4) | 32'h2000_0000, tag);
    probe(s ^ 32'h1000_0000, tag);
  endtask

  initial begin
    for (int r = 0; r < 4; r++) begin
      mEn[r] = 0; mCode[r] = 0; mBase[r] = 0; mRemap[r] = 0; mPort[r] = 0; mBurst[r] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state passes everything through
    probe(32'h0000_0000, "R1");
    probe(32'h0820_1234, "R1");
    probe(32'hFFFF_FFFF, "R1");

    // R2 R3 R4 R5: every size over several bases and targets
    for (int code = 1; code <= 7; code++) begin
      for (int b = 0; b < 4; b++) begin
        int unsigned base, remap;
        base  = (b == 0) ? 8'h00 : (b == 1) ? 8'hFF : (b == 2) ? 8'h5A : 8'h81;
        remap = (11'h4C3 ^ (code * 11'h111) ^ (b * 11'h2A5)) & 11'h7FF;
        writeRegion(0, 0, 0, 0, 0, 0, 0);
        writeRegion(0, 1, code, base, remap, b[0], b[1]);
        sweepWindow(code, base, "R2/R3/R4/R5 size sweep");
      end
    end

    // R2: enabled region with size code 0 never matches
    writeRegion(0, 0, 0, 0, 0, 0, 0);
    writeRegion(0, 1, 0, 8'h10, 11'h7FF, 1, 0);
    probe(32'h0200_0000, "R2 code0");
    probe(32'h0210_0000, "R2 code0");

    // R6: overlapping windows, lowest index wins
    writeRegion(0, 0, 0, 0, 0, 0, 0);
    writeRegion(3, 1, 7, 8'h00, 11'h400, 1, 1);  // 0..128MB
    writeRegion(2, 1, 5, 8'h10, 11'h300, 0, 0);  // 32..64MB
    writeRegion(1, 1, 3, 8'h14, 11'h200, 1, 0);  // 40..48MB
    writeRegion(0, 1, 1, 8'h15, 11'h100, 0, 1);  // 42..44MB
    for (int k = 0; k < 80; k++) probe(32'h0000_0000 + k * 32'h0020_0000 + k * 32'h0001_1111, "R6 priority");
    probe(32'h02A0_0000, "R6 region0");
    probe(32'h0280_0000, "R6 region1");
    probe(32'h0200_0000, "R6 region2");

    // R8: writes ignored while the cache is on
    cacheEnable = 1;
    writeRegion(0, 0, 0, 0, 0, 0, 0);
    writeRegion(1, 0, 0, 0, 0, 0, 0);
    probe(32'h02A0_0010, "R8 disable refused");
    probe(32'h0280_0010, "R8 disable refused");
    cacheEnable = 0;
    writeRegion(0, 0, 0, 0, 0, 0, 0);
    probe(32'h02A0_0010, "R8 accepted after cache off");

    // R9: rearming a live region is ignored; disable then rearm works
    writeRegion(1, 1, 3, 8'h14, 11'h7F0, 0, 1);
    probe(32'h0280_0010, "R9 live rewrite refused");
    writeRegion(1, 0, 3, 8'h14, 11'h200, 1, 0);
    probe(32'h0280_0010, "R9 disabled");
    writeRegion(1, 1, 3, 8'h14, 11'h7F0, 0, 1);
    probe(32'h0280_0010, "R9 rearmed");
    probe(32'h02FF_FFFC, "R9 rearmed");

    // R7: all off, default route
    for (int r = 0; r < 4; r++) writeRegion(r, 0, 0, 0, 0, 0, 0);
    probe(32'h0280_0010, "R7 default");
    probe(32'h8000_0000, "R7 default");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule